// File: doc/BRIEF.md
# Burst Address Counter with Load

This block supplies the per-port address used by a synchronous memory. In every clock cycle it settles on one internal address, chosen among four sources: zero, the external address bus, the previous address plus one, or the previous address unchanged. The chosen address drives the memory decoder in that same cycle. On the rising clock edge it is also kept as the counter value that the next cycle builds on.

The three controls are active low and follow a fixed priority. Counter clear beats the address strobe. The strobe beats count enable. Count enable beats hold. Clearing costs no dead cycle: a read or write issued together with the clear goes to address 0. The counter spans the whole address space and rolls over from the top address to zero. It does not look at chip enables and has no memory access logic of its own.

Top module: `burst_addr_counter`

## Requirements
- R1: While `cnt_clr_n` is 0, `mem_addr` is 0 in that same cycle, whatever `strobe_n`, `count_n` and `ext_addr` are.
- R2: While `cnt_clr_n` is 1 and `strobe_n` is 0, `mem_addr` equals `ext_addr` in that same cycle, and this value becomes the counter value.
- R3: While `cnt_clr_n` and `strobe_n` are both 1 and `count_n` is 0, `mem_addr` equals the previous cycle's `mem_addr` plus one, modulo 2^AW.
- R4: `count_n` has no effect in any cycle where `strobe_n` or `cnt_clr_n` is 0. The address is the one R1 or R2 gives, and no extra step is added.
- R5: While all three controls are 1, `mem_addr` equals the previous cycle's `mem_addr`, and changes on `ext_addr` have no effect.
- R6: A step from the all-ones address gives address 0.
- R7: After power-on reset (`rst_n` low), the counter holds 0. The first hold cycle after reset shows `mem_addr` = 0.
- R8: After a clear, a hold cycle shows 0 and a following step shows 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_addr | input | AW | External address bus |
| strobe_n | input | 1 | Address strobe, active low: use and load `ext_addr` |
| count_n | input | 1 | Count enable, active low: step the address by one |
| cnt_clr_n | input | 1 | Counter clear, active low: use and load address 0 |
| mem_addr | output | AW | Internal address for this cycle's access |

## Verification
The bench builds the counter with AW = 4, so the address space has 16 entries. Random runs of count enables reach the all-ones-to-zero rollover many times without directed set-up. Random strobes and clears overlap count enable often, which exercises every branch of the priority order. Directed cases add a clear that coincides with strobe and count enable, a strobe that coincides with count enable, and a hold cycle while the external bus toggles.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_STEP = 2'd2,
    SRC_KEEP = 2'd3
  } addr_src_e;

  // Fixed priority: clear > strobe > count > hold
  function automatic addr_src_e pick_source(input logic clr_n,
                                            input logic stb_n,
                                            input logic cnt_n);
    if (!clr_n)      return SRC_ZERO;
    else if (!stb_n) return SRC_EXT;
    else if (!cnt_n) return SRC_STEP;
    else             return SRC_KEEP;
  endfunction

endpackage

// File: rtl/bac_ctrl.sv
module bac_ctrl
  import bac_pkg::*;
(
  input  logic      clr_n,
  input  logic      stb_n,
  input  logic      cnt_n,
  output addr_src_e src
);

  always_comb begin
    src = pick_source(clr_n, stb_n, cnt_n);
  end

endmodule

// File: rtl/bac_step.sv
module bac_step #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt,
  output logic          at_top
);

  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    nxt    = step_addr(cur);
    at_top = (cur == TOP);
  end

endmodule

// File: rtl/bac_mux.sv
module bac_mux
  import bac_pkg::*;
#(
  parameter int AW = 14
) (
  input  addr_src_e     src,
  input  logic [AW-1:0] ext,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] addr
);

  always_comb begin
    unique case (src)
      SRC_ZERO: addr = '0;
      SRC_EXT:  addr = ext;
      SRC_STEP: addr = nxt;
      default:  addr = cur;
    endcase
  end

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          count_n,
  input  logic          cnt_clr_n,
  output logic [AW-1:0] mem_addr
);

  addr_src_e     src;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_inc;
  logic          cnt_at_top;
  logic          wrap_evt;
  logic          step_evt;

  bac_ctrl u_ctrl (
    .clr_n (cnt_clr_n),
    .stb_n (strobe_n),
    .cnt_n (count_n),
    .src   (src)
  );

  bac_step #(.AW(AW)) u_step (
    .cur    (cnt_q),
    .nxt    (cnt_inc),
    .at_top (cnt_at_top)
  );

  bac_mux #(.AW(AW)) u_mux (
    .src  (src),
    .ext  (ext_addr),
    .cur  (cnt_q),
    .nxt  (cnt_inc),
    .addr (mem_addr)
  );

  // Named events for the checker
  assign step_evt = (src == SRC_STEP);
  assign wrap_evt = step_evt && cnt_at_top;

  // The address used this cycle becomes the counter value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= mem_addr;
  end

endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          strobe_n,
  input logic          count_n,
  input logic          cnt_clr_n,
  input logic [AW-1:0] mem_addr,
  input logic          wrap_evt
);

  logic was_live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_live <= 1'b0;
    else        was_live <= 1'b1;
  end

  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr_n |-> (mem_addr == '0));

  a_r2_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr_n && !strobe_n) |-> (mem_addr == ext_addr));

  a_r2_loaded_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (was_live && cnt_clr_n && strobe_n && count_n && $past(cnt_clr_n && !strobe_n))
      |-> (mem_addr == $past(ext_addr)));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (was_live && cnt_clr_n && strobe_n && !count_n)
      |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (was_live && cnt_clr_n && strobe_n && count_n) |-> $stable(mem_addr));

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> (mem_addr == '0));

  a_r8_clear_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (was_live && cnt_clr_n && strobe_n && count_n && $past(!cnt_clr_n))
      |-> (mem_addr == '0));

endmodule

bind burst_addr_counter bac_checker #(.AW(AW)) u_bac_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_addr  (ext_addr),
  .strobe_n  (strobe_n),
  .count_n   (count_n),
  .cnt_clr_n (cnt_clr_n),
  .mem_addr  (mem_addr),
  .wrap_evt  (wrap_evt)
);

// File: tb/tb_burst_addr_counter.sv
`timescale 1ns/1ps
module tb_burst_addr_counter;

  localparam int TAW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [TAW-1:0] ext_addr = '0;
  logic           strobe_n = 1'b1;
  logic           count_n = 1'b1;
  logic           cnt_clr_n = 1'b1;
  logic [TAW-1:0] mem_addr;

  int n_checks = 0;
  int n_fail = 0;
  logic [TAW-1:0] prev_addr = '0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_counter #(.AW(TAW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .count_n   (count_n),
    .cnt_clr_n (cnt_clr_n),
    .mem_addr  (mem_addr)
  );

  // Reference model: controls packed as {clear_n, strobe_n, count_n}
  function automatic logic [TAW-1:0] ref_addr(input logic [2:0] ctl,
                                              input logic [TAW-1:0] ext,
                                              input logic [TAW-1:0] prev);
    casez (ctl)
      3'b0??:  return '0;
      3'b10?:  return ext;
      3'b110:  return (prev == {TAW{1'b1}}) ? '0 : prev + 1'b1;
      default: return prev;
    endcase
  endfunction

  task automatic check(input string req, input logic [TAW-1:0] got,
                       input logic [TAW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: mem_addr=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check the same-cycle address
  task automatic cycle(input string req, input logic clr_n, input logic stb_n,
                       input logic cnt_n, input logic [TAW-1:0] ext);
    logic [TAW-1:0] exp;
    @(negedge clk);
    cnt_clr_n = clr_n;
    strobe_n  = stb_n;
    count_n   = cnt_n;
    ext_addr  = ext;
    #1;
    exp = ref_addr({clr_n, stb_n, cnt_n}, ext, prev_addr);
    check(req, mem_addr, exp);
    prev_addr = exp;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, got=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset", mem_addr, '0);
    @(negedge clk);
    rst_n = 1'b1;
    cycle("R7 first hold after reset", 1'b1, 1'b1, 1'b1, 4'd9);
    cycle("R2 load", 1'b1, 1'b0, 1'b1, 4'd5);
    cycle("R5 hold keeps loaded", 1'b1, 1'b1, 1'b1, 4'd12);
    cycle("R3 step", 1'b1, 1'b1, 1'b0, 4'd0);
    cycle("R3 step again", 1'b1, 1'b1, 1'b0, 4'd3);
    cycle("R5 hold ext ignored", 1'b1, 1'b1, 1'b1, 4'd15);
    cycle("R5 hold ext ignored 2", 1'b1, 1'b1, 1'b1, 4'd1);
    cycle("R4 count ignored with strobe", 1'b1, 1'b0, 1'b0, 4'd14);
    cycle("R6 step to top", 1'b1, 1'b1, 1'b0, 4'd0);
    cycle("R6 wrap to zero", 1'b1, 1'b1, 1'b0, 4'd0);
    cycle("R2 load before clear", 1'b1, 1'b0, 1'b1, 4'd10);
    cycle("R1 clear beats strobe and count", 1'b0, 1'b0, 1'b0, 4'd7);
    cycle("R8 hold after clear", 1'b1, 1'b1, 1'b1, 4'd6);
    cycle("R8 step after clear", 1'b1, 1'b1, 1'b0, 4'd6);
    cycle("R4 count ignored with clear", 1'b0, 1'b1, 1'b0, 4'd3);
    cycle("R4 no extra step after clear", 1'b1, 1'b1, 1'b1, 4'd3);

    for (int i = 0; i < 600; i++) begin
      logic clr_r, stb_r, cnt_r;
      clr_r = ($urandom_range(0, 9) != 0);
      stb_r = ($urandom_range(0, 4) != 0);
      cnt_r = ($urandom_range(0, 2) == 0);
      cycle("R1/R2/R3/R5 random", clr_r, stb_r, cnt_r, TAW'($urandom));
    end

    done = 1'b1;
    finish_run();
  end

endmodule